// File: doc/BRIEF.md
# Split-Transaction Pairing and Latency Monitor

This block watches a split request/response interface whose transactions carry a 4-bit identifier. It is fully passive: it only samples a request strobe with its ID and a response strobe with its ID. It never drives the interface. For every ID value it keeps a small state machine with an age counter, so up to sixteen transactions can be tracked at the same time. The error outputs are single-cycle pulses that go high in the exact cycle a rule is broken. This lets a verification environment or an on-chip debug trace localise each fault at its source.

Each per-ID tracker has two named states. In `SLOT_IDLE` no request with that ID is open. In `SLOT_PEND` a request is open, and the age counter holds the number of cycles since the request cycle. The transitions are:
- IDLE→PEND on a request.
- PEND→PEND (age restarts at 1) on a repeated request.
- PEND→IDLE on a matching response (retire).
- PEND→IDLE when the age passes the bound (expire).
- IDLE→IDLE on a response, which is an orphan.
- PEND→PEND (age + 1) on any other cycle.

There are three separate error outputs:
- An unmatched response.
- A latency overrun.
- A request reusing an ID that is still open.

All error outputs are held low while the active-low reset is asserted.

Top module: `txn_order_monitor`

## Requirements
- R1: A response whose ID has no open request drives `err_orphan` high in the same cycle as the response; with no strobe active, `err_orphan` and `err_dup_id` stay low.
- R2: A response matching an open request retires it, so a second response with the same ID in a later cycle is an orphan.
- R3: A response in the same cycle as the request carrying its ID is an orphan (minimum latency is one cycle); the request is still recorded.
- R4: A response arriving 1 to MAX_LATENCY cycles after its request cycle raises no error, including exactly MAX_LATENCY cycles after.
- R5: If no response has arrived by MAX_LATENCY cycles after the request, `err_timeout` pulses in cycle MAX_LATENCY+1 for exactly one cycle and the entry is cleared; a response in that cycle is also an orphan.
- R6: A request whose ID is already open (and not retired in that same cycle) pulses `err_dup_id` and restarts that ID's latency count from the request cycle.
- R7: A request and a response in the same cycle are handled independently; when they carry the same open ID, the old entry retires and a new one opens with no error.
- R8: While `rst_n` is low all errors are low; reset clears every open entry and age count, so no timeout follows from requests made before reset, and a later response to them is an orphan.
- R9: All 16 ID values are tracked concurrently, each with its own age counter, so staggered open requests time out one per cycle in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; disables checking |
| req_vld | input | 1 | Request strobe for this cycle |
| req_id | input | 4 | Identifier of the request |
| rsp_vld | input | 1 | Response strobe for this cycle |
| rsp_id | input | 4 | Identifier of the response |
| err_orphan | output | 1 | Unmatched or too-early/too-late response |
| err_timeout | output | 1 | An open request exceeded MAX_LATENCY |
| err_dup_id | output | 1 | Request reused an ID that is still open |

## Verification
The properties assume that the strobes and IDs are settled, known values at each rising edge. They also assume MAX_LATENCY is at least one, so a request is still open one cycle later. They expect at most one request and one response per cycle, which the interface width itself enforces. The stimulus drives every input shortly after the falling edge and holds it steady through the next rising edge. Reset is released on a falling edge, so no property samples a request made while the trackers were still held in reset.

// File: rtl/txn_mon_pkg.sv
package txn_mon_pkg;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_t;

    typedef struct packed {
        logic orphan;
        logic timeout;
        logic dup;
    } slot_err_t;

endpackage

// File: rtl/txn_slot.sv
module txn_slot
    import txn_mon_pkg::*;
#(
    parameter int MAX_LATENCY = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit_req,
    input  logic      hit_rsp,
    output slot_err_t err
);
    localparam int AGE_W = $clog2(MAX_LATENCY + 2);

    slot_state_t      state_q, state_nx;
    logic [AGE_W-1:0] age_q, age_nx;
    logic             expire;
    logic             live;
    logic             retire;

    // entry has passed its bound this cycle
    assign expire = (state_q == SLOT_PEND) && (age_q > AGE_W'(MAX_LATENCY));
    assign live   = (state_q == SLOT_PEND) && !expire;
    assign retire = hit_rsp && live;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            age_q   <= '0;
        end else begin
            state_q <= state_nx;
            age_q   <= age_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        age_nx   = age_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (hit_req) begin
                    state_nx = SLOT_PEND;
                    age_nx   = AGE_W'(1);
                end
            end
            SLOT_PEND: begin
                if (hit_req) begin
                    age_nx = AGE_W'(1);
                end else if (retire || expire) begin
                    state_nx = SLOT_IDLE;
                    age_nx   = '0;
                end else begin
                    age_nx = AGE_W'(age_q + 1'b1);
                end
            end
            default: begin
                state_nx = SLOT_IDLE;
                age_nx   = '0;
            end
        endcase
    end

    // per-rule outputs
    always_comb begin
        err         = '0;
        err.orphan  = hit_rsp && !live;
        err.timeout = expire;
        err.dup     = hit_req && live && !hit_rsp;
    end

endmodule

// File: rtl/txn_err_merge.sv
module txn_err_merge
    import txn_mon_pkg::*;
#(
    parameter int N_SLOTS = 16
) (
    input  slot_err_t [N_SLOTS-1:0] slot_errs,
    output slot_err_t               any_err
);
    always_comb begin
        any_err = '0;
        for (int k = 0; k < N_SLOTS; k++) begin
            any_err.orphan  = any_err.orphan  | slot_errs[k].orphan;
            any_err.timeout = any_err.timeout | slot_errs[k].timeout;
            any_err.dup     = any_err.dup     | slot_errs[k].dup;
        end
    end
endmodule

// File: rtl/txn_order_monitor.sv
module txn_order_monitor
    import txn_mon_pkg::*;
#(
    parameter int ID_W        = 4,
    parameter int MAX_LATENCY = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_vld,
    input  logic [ID_W-1:0] req_id,
    input  logic            rsp_vld,
    input  logic [ID_W-1:0] rsp_id,
    output logic            err_orphan,
    output logic            err_timeout,
    output logic            err_dup_id
);
    localparam int N_IDS = 2 ** ID_W;

    slot_err_t [N_IDS-1:0] slot_errs;
    slot_err_t             merged;

    for (genvar g = 0; g < N_IDS; g++) begin : g_slot
        logic hit_req;
        logic hit_rsp;
        assign hit_req = req_vld && (req_id == ID_W'(g));
        assign hit_rsp = rsp_vld && (rsp_id == ID_W'(g));

        txn_slot #(
            .MAX_LATENCY(MAX_LATENCY)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_req(hit_req),
            .hit_rsp(hit_rsp),
            .err    (slot_errs[g])
        );
    end

    txn_err_merge #(
        .N_SLOTS(N_IDS)
    ) u_merge (
        .slot_errs(slot_errs),
        .any_err  (merged)
    );

    // checking is off while reset is held
    assign err_orphan  = rst_n && merged.orphan;
    assign err_timeout = rst_n && merged.timeout;
    assign err_dup_id  = rst_n && merged.dup;

endmodule

// File: rtl/txn_order_monitor_chk.sv
module txn_order_monitor_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_vld,
    input logic [ID_W-1:0] req_id,
    input logic            rsp_vld,
    input logic [ID_W-1:0] rsp_id,
    input logic            err_orphan,
    input logic            err_timeout,
    input logic            err_dup_id
);
    p_quiet_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld && !rsp_vld) |-> (!err_orphan && !err_dup_id));

    p_next_cycle_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_vld) ##1 (rsp_vld && rsp_id == $past(req_id)) |-> !err_orphan);

    p_reuse_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_vld) ##1 (req_vld && req_id == $past(req_id)
                                && !(rsp_vld && rsp_id == req_id)) |-> err_dup_id);

    p_clean_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!err_timeout && !err_dup_id));

endmodule

bind txn_order_monitor txn_order_monitor_chk #(.ID_W(ID_W)) u_chk (.*);

// File: tb/txn_order_monitor_bench.sv
`timescale 1ns/1ps
module txn_order_monitor_bench;
    localparam int MAXL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld = 1'b0;
    logic [3:0] req_id = '0;
    logic       rsp_vld = 1'b0;
    logic [3:0] rsp_id = '0;
    logic       err_orphan, err_timeout, err_dup_id;

    int checks = 0;
    int errs   = 0;

    always #4 clk = ~clk;  // 125 MHz

    txn_order_monitor #(.ID_W(4), .MAX_LATENCY(MAXL)) u_txn_order_monitor (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_id(req_id),
        .rsp_vld(rsp_vld), .rsp_id(rsp_id),
        .err_orphan(err_orphan), .err_timeout(err_timeout), .err_dup_id(err_dup_id)
    );

    // {req_vld, req_id, rsp_vld, rsp_id, exp orphan/timeout/dup}
    localparam int NV = 29;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'h3, 1'b0, 4'h0, 3'b000},  // 0  open 3
        {1'b0, 4'h0, 1'b1, 4'h3, 3'b000},  // 1  R4 age 1 legal
        {1'b0, 4'h0, 1'b1, 4'h3, 3'b100},  // 2  R2 already retired
        {1'b1, 4'h5, 1'b1, 4'h5, 3'b100},  // 3  R3 same-cycle response
        {1'b0, 4'h0, 1'b1, 4'h5, 3'b000},  // 4  R3 request still recorded
        {1'b1, 4'h7, 1'b0, 4'h0, 3'b000},  // 5  open 7
        {1'b1, 4'h7, 1'b0, 4'h0, 3'b001},  // 6  R6 reuse
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 7  R6 age restarted: 1
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 8
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 9
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 10 age = MAX
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b010},  // 11 R5 overrun
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 12 R5 single pulse
        {1'b0, 4'h0, 1'b1, 4'h7, 3'b100},  // 13 R5 entry cleared
        {1'b1, 4'h1, 1'b0, 4'h0, 3'b000},  // 14 open 1
        {1'b1, 4'h2, 1'b1, 4'h1, 3'b000},  // 15 R7 different IDs
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 16
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 17
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 18
        {1'b0, 4'h0, 1'b1, 4'h2, 3'b000},  // 19 R4 exactly MAX
        {1'b1, 4'h9, 1'b0, 4'h0, 3'b000},  // 20 open 9
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 21
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 22
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 23
        {1'b0, 4'h0, 1'b0, 4'h0, 3'b000},  // 24
        {1'b0, 4'h0, 1'b1, 4'h9, 3'b110},  // 25 R5 late response
        {1'b1, 4'hA, 1'b0, 4'h0, 3'b000},  // 26 open A
        {1'b1, 4'hA, 1'b1, 4'hA, 3'b000},  // 27 R7 retire and reopen
        {1'b0, 4'h0, 1'b1, 4'hA, 3'b000}   // 28 R7 new entry legal
    };

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] got;
        got = {err_orphan, err_timeout, err_dup_id};
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: orphan/timeout/dup got %b expected %b", tag, got, exp);
        end
    endtask

    // drive after falling edge, sample 2 ns later (before the rising edge)
    task automatic step(input logic rv, input logic [3:0] rid,
                        input logic sv, input logic [3:0] sid);
        @(negedge clk);
        req_vld = rv; req_id = rid; rsp_vld = sv; rsp_id = sid;
        #2;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R8: outputs low while held in reset, even with a response strobe
        step(1'b1, 4'h4, 1'b1, 4'h0);
        chk("R8 reset quiet", 3'b000);
        step(1'b0, 4'h0, 1'b0, 4'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            step(v[12], v[11:8], v[7], v[6:3]);
            chk($sformatf("table[%0d] R1..R7", i), v[2:0]);
        end

        // R1: response on an ID never requested
        step(1'b0, 4'h0, 1'b1, 4'hE);
        chk("R1 unmatched", 3'b100);
        step(1'b0, 4'h0, 1'b0, 4'h0);
        chk("R1 idle quiet", 3'b000);

        // R8: reset clears an open entry
        step(1'b1, 4'hB, 1'b0, 4'h0);
        chk("R8 open B", 3'b000);
        @(negedge clk);
        req_vld = 1'b0;
        rst_n = 1'b0;
        step(1'b0, 4'h0, 1'b0, 4'h0);
        rst_n = 1'b1;
        for (int i = 0; i < MAXL + 3; i++) begin
            step(1'b0, 4'h0, 1'b0, 4'h0);
            chk("R8 no timeout after reset", 3'b000);
        end
        step(1'b0, 4'h0, 1'b1, 4'hB);
        chk("R8 entry cleared", 3'b100);

        // R9: all 16 IDs open at once, staggered timeouts
        for (int c = 0; c < 21; c++) begin
            step(c < 16, 4'(c), 1'b0, 4'h0);
            chk($sformatf("R9 cycle %0d", c), (c >= MAXL + 1) ? 3'b010 : 3'b000);
        end
        step(1'b0, 4'h0, 1'b0, 4'h0);
        chk("R9 drained", 3'b000);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule